// File: doc/BRIEF.md
# SMBus Command Sequencer

This block sits between a host that wants whole SMBus commands carried out and a byte-level I2C engine that can only move one frame byte at a time. The host hands over one request (a command kind, a 7-bit target, a command code and up to two data bytes). The sequencer expands it into an ordered list of engine operations. Each operation is marked as an address frame or a data byte, a write or a read, and may carry a stop or repeated-start request.

After issuing each operation the sequencer waits for the engine to report completion or failure. A bounded timer limits each wait. Read bytes are gathered into a 16-bit result. If any step fails or times out, the sequencer sends a bare stop operation that also clears the engine's error flags, and only then reports the error. Each request ends with a one-cycle `done` pulse. `err` pulses in the same cycle when the command failed.

Top module: `smb_cmd_seq`

## Requirements
- R1: The byte sent for an address frame (`eng_frame`=1) is the 7-bit target in bits 7..1, with bit 0 = 1 for a read-direction frame and 0 for a write-direction frame.
- R2: Kind 0 (quick write) and kind 1 (quick read) issue exactly one operation: an address frame with write bit or read bit respectively and `eng_stop`=1.
- R3: Kind 2 (send byte) issues a write address frame, then the low data byte with stop. Kind 3 (receive byte) issues a read address frame, then one read operation (`eng_read`=1, byte 0) with stop.
- R4: Kind 4 (write byte) issues write address, command code, then low data byte. Kind 6 (write word) issues write address, command code, low data byte, then high data byte. Only the final operation carries stop, and none carries repeated start.
- R5: Kind 5 (read byte) issues write address, command code with `eng_rsr`=1, read address, then one read. Kind 7 (read word) has the same order with two reads. Stop is set only on the last read.
- R6: At `done`, `rdata` holds the received byte zero-extended for kinds 3 and 5. For kind 7 it holds the first received byte in bits 7..0 and the second in bits 15..8.
- R7: A step completes on either `ev_tx_done` or `ev_master_done`. The next operation is issued in the cycle after the completion event is sampled.
- R8: An `ev_data_nak`, `ev_addr_nak` or `ev_arb_lost` event during a step stops the command. In the next cycle one abort operation is issued (`eng_go`, `eng_abort`, `eng_stop` and `eng_clr_ev` all 1, `eng_frame` and `eng_read` 0). `done` and `err` pulse in the cycle after that.
- R9: If a step sees no event, the abort operation of R8 appears WAIT_POLLS*POLL_CYCLES+1 cycles (41 by default) after that step was issued, followed by `done` with `err`.
- R10: Kinds 8 to 15 are rejected. `done` and `err` pulse in the cycle after acceptance, and no engine operation is issued.
- R11: `req_ready` is 1 only while idle. A request is taken on `req_valid`&&`req_ready`, and `req_valid` while busy has no effect. An accepted supported request issues its first operation (an address frame) in the next cycle.
- R12: `done` is a one-cycle pulse, `err` is high only together with `done`, and `rdata` stays unchanged in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_kind | input | 4 | Command kind, 0..7 supported |
| req_addr | input | 7 | Target address |
| req_code | input | 8 | Command code |
| req_wdata | input | 16 | Write data, low byte sent first |
| done | output | 1 | End-of-command pulse |
| err | output | 1 | Failure pulse, only with done |
| rdata | output | 16 | Collected read data |
| eng_go | output | 1 | Operation strobe to the byte engine |
| eng_frame | output | 1 | Operation is an address frame (start before it) |
| eng_read | output | 1 | Operation receives a byte |
| eng_stop | output | 1 | Stop after this operation |
| eng_rsr | output | 1 | Repeated start after this operation |
| eng_abort | output | 1 | Bare stop to release the bus |
| eng_clr_ev | output | 1 | Clear the engine's error flags |
| eng_byte | output | 8 | Byte to transmit |
| ev_tx_done | input | 1 | Engine: byte transmitted |
| ev_master_done | input | 1 | Engine: master operation finished |
| ev_data_nak | input | 1 | Engine: data byte not acknowledged |
| ev_addr_nak | input | 1 | Engine: address not acknowledged |
| ev_arb_lost | input | 1 | Engine: arbitration lost |
| eng_rx_byte | input | 8 | Received byte, valid with the completion event |

## Verification
Every supported kind is run with several address, code and data patterns, including the extreme addresses 0x00 and 0x7F. These runs show whether the read/write bit, the repeated-start and stop placement and the low-before-high byte order are right for each kind. Each kind is also completed once through the master-done event alone, which shows that both completion events are accepted. A failure of each of the three error types is injected at every step of every kind. This shows whether the abort is issued on time and whether no operation leaks after a failed step. Timeouts on selected steps, every unsupported kind, and a request held valid while busy cover the timer limit, the rejection path and the handshake.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int KIND_W = 4;
    localparam int IDX_W  = 3;

    localparam logic [KIND_W-1:0] K_QUICK_WR = 4'd0;
    localparam logic [KIND_W-1:0] K_QUICK_RD = 4'd1;
    localparam logic [KIND_W-1:0] K_SEND     = 4'd2;
    localparam logic [KIND_W-1:0] K_RECV     = 4'd3;
    localparam logic [KIND_W-1:0] K_WR_BYTE  = 4'd4;
    localparam logic [KIND_W-1:0] K_RD_BYTE  = 4'd5;
    localparam logic [KIND_W-1:0] K_WR_WORD  = 4'd6;
    localparam logic [KIND_W-1:0] K_RD_WORD  = 4'd7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_WAIT, ST_ABORT, ST_REPORT
    } seq_state_e;

    typedef enum logic [2:0] {
        STEP_ADDR_W, STEP_ADDR_R, STEP_CODE, STEP_DLO, STEP_DHI, STEP_RD
    } step_e;

    typedef struct packed {
        logic              frame;
        logic              rd;
        logic              stop;
        logic              rsr;
        logic [BYTE_W-1:0] data;
    } eng_op_t;

    function automatic logic kind_known(input logic [KIND_W-1:0] k);
        return k <= K_RD_WORD;
    endfunction
endpackage

// File: rtl/smb_step_decode.sv
module smb_step_decode
    import smb_seq_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] code,
    input  logic [WORD_W-1:0] wdata,
    output eng_op_t           op,
    output logic              last,
    output logic              rd_high
);
    step_e stype;
    logic  rsr;

    always_comb begin
        stype = STEP_ADDR_W;
        last  = 1'b0;
        rsr   = 1'b0;
        case (kind)
            K_QUICK_WR: begin stype = STEP_ADDR_W; last = 1'b1; end
            K_QUICK_RD: begin stype = STEP_ADDR_R; last = 1'b1; end
            K_SEND: begin
                stype = (idx == 3'd0) ? STEP_ADDR_W : STEP_DLO;
                last  = (idx == 3'd1);
            end
            K_RECV: begin
                stype = (idx == 3'd0) ? STEP_ADDR_R : STEP_RD;
                last  = (idx == 3'd1);
            end
            K_WR_BYTE: begin
                case (idx)
                    3'd0:    stype = STEP_ADDR_W;
                    3'd1:    stype = STEP_CODE;
                    default: begin stype = STEP_DLO; last = 1'b1; end
                endcase
            end
            K_WR_WORD: begin
                case (idx)
                    3'd0:    stype = STEP_ADDR_W;
                    3'd1:    stype = STEP_CODE;
                    3'd2:    stype = STEP_DLO;
                    default: begin stype = STEP_DHI; last = 1'b1; end
                endcase
            end
            K_RD_BYTE: begin
                case (idx)
                    3'd0:    stype = STEP_ADDR_W;
                    3'd1:    begin stype = STEP_CODE; rsr = 1'b1; end
                    3'd2:    stype = STEP_ADDR_R;
                    default: begin stype = STEP_RD; last = 1'b1; end
                endcase
            end
            K_RD_WORD: begin
                case (idx)
                    3'd0:    stype = STEP_ADDR_W;
                    3'd1:    begin stype = STEP_CODE; rsr = 1'b1; end
                    3'd2:    stype = STEP_ADDR_R;
                    3'd3:    stype = STEP_RD;
                    default: begin stype = STEP_RD; last = 1'b1; end
                endcase
            end
            default: begin stype = STEP_ADDR_W; last = 1'b1; end
        endcase
    end

    assign rd_high = (kind == K_RD_WORD) && (idx == 3'd4);

    always_comb begin
        op      = '0;
        op.stop = last;
        op.rsr  = rsr;
        case (stype)
            STEP_ADDR_W: begin op.frame = 1'b1; op.data = {addr, 1'b0}; end
            STEP_ADDR_R: begin op.frame = 1'b1; op.data = {addr, 1'b1}; end
            STEP_CODE:   op.data = code;
            STEP_DLO:    op.data = wdata[BYTE_W-1:0];
            STEP_DHI:    op.data = wdata[WORD_W-1:BYTE_W];
            STEP_RD:     op.rd   = 1'b1;
            default:     op.data = '0;
        endcase
    end
endmodule

// File: rtl/smb_step_timer.sv
module smb_step_timer #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (run) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/smb_cmd_seq.sv
module smb_cmd_seq
    import smb_seq_pkg::*;
#(
    parameter int WAIT_POLLS  = 10,
    parameter int POLL_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_code,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] rdata,
    output logic              eng_go,
    output logic              eng_frame,
    output logic              eng_read,
    output logic              eng_stop,
    output logic              eng_rsr,
    output logic              eng_abort,
    output logic              eng_clr_ev,
    output logic [BYTE_W-1:0] eng_byte,
    input  logic              ev_tx_done,
    input  logic              ev_master_done,
    input  logic              ev_data_nak,
    input  logic              ev_addr_nak,
    input  logic              ev_arb_lost,
    input  logic [BYTE_W-1:0] eng_rx_byte
);
    localparam int STEP_LIMIT = WAIT_POLLS * POLL_CYCLES;

    typedef struct packed {
        seq_state_e        st;
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] code;
        logic [WORD_W-1:0] wdata;
        logic [IDX_W-1:0]  idx;
        logic              fail;
        logic [WORD_W-1:0] rdata;
    } seq_t;

    seq_t    s_d, s_q;
    eng_op_t op;
    logic    step_last, step_hi;
    logic    tmr_clr, tmr_run, tmr_expired;
    logic    ev_ok, ev_bad;

    smb_step_decode u_dec (
        .kind    (s_q.kind),
        .idx     (s_q.idx),
        .addr    (s_q.addr),
        .code    (s_q.code),
        .wdata   (s_q.wdata),
        .op      (op),
        .last    (step_last),
        .rd_high (step_hi)
    );

    smb_step_timer #(.LIMIT(STEP_LIMIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    assign ev_ok  = ev_tx_done | ev_master_done;
    assign ev_bad = ev_data_nak | ev_addr_nak | ev_arb_lost;

    always_comb begin
        s_d        = s_q;
        req_ready  = 1'b0;
        done       = 1'b0;
        err        = 1'b0;
        eng_go     = 1'b0;
        eng_frame  = 1'b0;
        eng_read   = 1'b0;
        eng_stop   = 1'b0;
        eng_rsr    = 1'b0;
        eng_abort  = 1'b0;
        eng_clr_ev = 1'b0;
        eng_byte   = '0;
        tmr_clr    = 1'b0;
        tmr_run    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    s_d.kind  = req_kind;
                    s_d.addr  = req_addr;
                    s_d.code  = req_code;
                    s_d.wdata = req_wdata;
                    s_d.idx   = '0;
                    s_d.fail  = !kind_known(req_kind);
                    s_d.st    = kind_known(req_kind) ? ST_ISSUE : ST_REPORT;
                end
            end
            ST_ISSUE: begin
                eng_go    = 1'b1;
                eng_frame = op.frame;
                eng_read  = op.rd;
                eng_stop  = op.stop;
                eng_rsr   = op.rsr;
                eng_byte  = op.data;
                tmr_clr   = 1'b1;
                s_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                tmr_run = 1'b1;
                if (ev_bad) begin
                    s_d.st = ST_ABORT;
                end else if (ev_ok) begin
                    if (op.rd) begin
                        if (step_hi) s_d.rdata[WORD_W-1:BYTE_W] = eng_rx_byte;
                        else         s_d.rdata = {{BYTE_W{1'b0}}, eng_rx_byte};
                    end
                    if (step_last) begin
                        s_d.st = ST_REPORT;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.st  = ST_ISSUE;
                    end
                end else if (tmr_expired) begin
                    s_d.st = ST_ABORT;
                end
            end
            ST_ABORT: begin
                eng_go     = 1'b1;
                eng_abort  = 1'b1;
                eng_stop   = 1'b1;
                eng_clr_ev = 1'b1;
                s_d.fail   = 1'b1;
                s_d.st     = ST_REPORT;
            end
            ST_REPORT: begin
                done   = 1'b1;
                err    = s_q.fail;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;
endmodule

// File: rtl/smb_cmd_seq_chk.sv
module smb_cmd_seq_chk
    import smb_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [KIND_W-1:0] req_kind,
    input logic              done,
    input logic              err,
    input logic [WORD_W-1:0] rdata,
    input logic              eng_go,
    input logic              eng_frame,
    input logic              eng_read,
    input logic              eng_stop,
    input logic              eng_abort,
    input logic              eng_clr_ev
);
    AST_GO_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> !req_ready); // R11
    AST_FIRST_IS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind <= K_RD_WORD) |=> (eng_go && eng_frame && !eng_abort)); // R11
    AST_BAD_KIND_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind > K_RD_WORD) |=> (done && err && !eng_go)); // R10
    AST_ABORT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> (eng_go && eng_stop && eng_clr_ev && !eng_frame && !eng_read)); // R8
    AST_ABORT_THEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> (done && err)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R12
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(rdata)); // R12
endmodule

bind smb_cmd_seq smb_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_kind   (req_kind),
    .done       (done),
    .err        (err),
    .rdata      (rdata),
    .eng_go     (eng_go),
    .eng_frame  (eng_frame),
    .eng_read   (eng_read),
    .eng_stop   (eng_stop),
    .eng_abort  (eng_abort),
    .eng_clr_ev (eng_clr_ev)
);

// File: tb/smb_cmd_seq_bench.sv
module smb_cmd_seq_bench;
    localparam int LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_kind = '0;
    logic [6:0]  req_addr = '0;
    logic [7:0]  req_code = '0;
    logic [15:0] req_wdata = '0;
    logic        done, err;
    logic [15:0] rdata;
    logic        eng_go, eng_frame, eng_read, eng_stop, eng_rsr, eng_abort, eng_clr_ev;
    logic [7:0]  eng_byte;
    logic        ev_tx_done = 1'b0, ev_master_done = 1'b0;
    logic        ev_data_nak = 1'b0, ev_addr_nak = 1'b0, ev_arb_lost = 1'b0;
    logic [7:0]  eng_rx_byte = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    smb_cmd_seq u_smb_cmd_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_code(req_code), .req_wdata(req_wdata),
        .done(done), .err(err), .rdata(rdata),
        .eng_go(eng_go), .eng_frame(eng_frame), .eng_read(eng_read),
        .eng_stop(eng_stop), .eng_rsr(eng_rsr), .eng_abort(eng_abort),
        .eng_clr_ev(eng_clr_ev), .eng_byte(eng_byte),
        .ev_tx_done(ev_tx_done), .ev_master_done(ev_master_done),
        .ev_data_nak(ev_data_nak), .ev_addr_nak(ev_addr_nak),
        .ev_arb_lost(ev_arb_lost), .eng_rx_byte(eng_rx_byte)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int k);
        case (k)
            0, 1:    return 1;
            2, 3:    return 2;
            4:       return 3;
            5, 6:    return 4;
            7:       return 5;
            default: return 0;
        endcase
    endfunction

    // {frame, read, stop, rsr, byte}
    function automatic logic [11:0] exp_op(input int k, input int i, input logic [6:0] a,
                                           input logic [7:0] c, input logic [15:0] w);
        logic fr, rd, sp, rs;
        logic [7:0] by;
        fr = 0; rd = 0; rs = 0; by = 8'h00;
        sp = (i == exp_len(k) - 1);
        case (k)
            0: begin fr = 1; by = {a, 1'b0}; end
            1: begin fr = 1; by = {a, 1'b1}; end
            2: if (i == 0) begin fr = 1; by = {a, 1'b0}; end else by = w[7:0];
            3: if (i == 0) begin fr = 1; by = {a, 1'b1}; end else rd = 1;
            4, 6: case (i)
                0: begin fr = 1; by = {a, 1'b0}; end
                1: by = c;
                2: by = w[7:0];
                default: by = w[15:8];
            endcase
            default: case (i)
                0: begin fr = 1; by = {a, 1'b0}; end
                1: begin by = c; rs = 1; end
                2: begin fr = 1; by = {a, 1'b1}; end
                default: rd = 1;
            endcase
        endcase
        return {fr, rd, sp, rs, by};
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            0, 1:    return "R2";
            2, 3:    return "R3";
            4, 6:    return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [7:0] rx_pat(input int k, input int s);
        return 8'h96 ^ {k[3:0], s[3:0]};
    endfunction

    // ftype: 0 ok via tx_done, 1 ok via master_done, 2 data nak, 3 addr nak, 4 arb lost, 5 timeout
    task automatic run(input int kind, input logic [6:0] a, input logic [7:0] c,
                       input logic [15:0] w, input int fstep, input int ftype, input bit hold);
        logic [11:0] got [0:7];
        int nops = 0, pend = -1, go_cyc = -1, abort_cyc = -1, done_cyc = -1, resp_cyc = -1;
        bit fin = 0, got_err = 0, ready_busy = 0;
        logic [15:0] got_rd = '0;
        int exp_n;
        bit fails;
        fails = (kind > 7) || (ftype >= 2);
        exp_n = (kind > 7) ? 0 : (ftype >= 2 ? fstep + 1 : exp_len(kind));
        @(negedge clk);
        req_kind = 4'(kind); req_addr = a; req_code = c; req_wdata = w; req_valid = 1'b1;
        @(negedge clk);
        if (hold) req_kind = 4'd15; else req_valid = 1'b0;
        for (int cyc = 0; cyc < 300 && !fin; cyc++) begin
            if (cyc > 0) @(negedge clk);
            ev_tx_done = 0; ev_master_done = 0; ev_data_nak = 0; ev_addr_nak = 0; ev_arb_lost = 0;
            if (req_ready) ready_busy = 1;
            if (eng_go) begin
                if (eng_abort) begin
                    abort_cyc = cyc;
                    chk(eng_stop && eng_clr_ev && !eng_frame && !eng_read, "R8", "abort op flags",
                        {eng_stop, eng_clr_ev, eng_frame, eng_read}, 4'b1100);
                end else begin
                    if (nops < 8) got[nops] = {eng_frame, eng_read, eng_stop, eng_rsr, eng_byte};
                    nops++;
                    go_cyc = cyc;
                    pend = (nops - 1 == fstep && ftype == 5) ? -1 : cyc + 2;
                end
            end
            if (cyc == pend) begin
                resp_cyc = cyc;
                eng_rx_byte = rx_pat(kind, nops - 1);
                if (nops - 1 == fstep && ftype == 2) ev_data_nak = 1;
                else if (nops - 1 == fstep && ftype == 3) ev_addr_nak = 1;
                else if (nops - 1 == fstep && ftype == 4) ev_arb_lost = 1;
                else if (ftype == 1) ev_master_done = 1;
                else ev_tx_done = 1;
            end
            if (done) begin
                fin = 1; got_err = err; got_rd = rdata; done_cyc = cyc;
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        ev_tx_done = 0; ev_master_done = 0; ev_data_nak = 0; ev_addr_nak = 0; ev_arb_lost = 0;
        chk(fin, "R12", "done seen", fin, 1);
        chk(!done, "R12", "done one cycle", done, 0);
        chk(rdata == got_rd, "R12", "rdata held", rdata, got_rd);
        chk(!ready_busy, "R11", "ready low while busy", ready_busy, 0);
        chk(nops == exp_n, kind > 7 ? "R10" : tag_of(kind), "op count", nops, exp_n);
        for (int i = 0; i < exp_n && i < nops; i++) begin
            logic [11:0] e;
            e = exp_op(kind, i, a, c, w);
            chk(got[i] == e, e[11] ? "R1" : tag_of(kind), "op content", got[i], e);
        end
        chk(got_err == fails, kind > 7 ? "R10" : (ftype == 1 ? "R7" : "R8"), "err flag", got_err, fails);
        if (kind > 7) begin
            chk(done_cyc == 0, "R10", "reject latency", done_cyc, 0);
        end else if (ftype == 5) begin
            chk(abort_cyc - go_cyc == LIMIT + 1, "R9", "timeout abort delay", abort_cyc - go_cyc, LIMIT + 1);
            chk(done_cyc == abort_cyc + 1, "R9", "done after abort", done_cyc - abort_cyc, 1);
        end else if (ftype >= 2) begin
            chk(abort_cyc == resp_cyc + 1, "R8", "abort delay", abort_cyc - resp_cyc, 1);
            chk(done_cyc == abort_cyc + 1, "R8", "done after abort", done_cyc - abort_cyc, 1);
        end else begin
            logic [15:0] er;
            chk(abort_cyc < 0, "R7", "no abort on success", abort_cyc, 32'hffffffff);
            chk(done_cyc == resp_cyc + 1, "R7", "done latency", done_cyc - resp_cyc, 1);
            if (kind == 3 || kind == 5 || kind == 7) begin
                er = (kind == 7) ? {rx_pat(7, 4), rx_pat(7, 3)}
                                 : {8'h00, rx_pat(kind, kind == 3 ? 1 : 3)};
                chk(got_rd == er, "R6", "read data", got_rd, er);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R11", "reset ready", req_ready, 1);
        chk(!done && !err && !eng_go, "R12", "reset outputs", {done, err, eng_go}, 0);
        chk(rdata == 16'h0, "R12", "reset rdata", rdata, 0);
        for (int k = 0; k < 8; k++) begin
            run(k, 7'h00, 8'hA5, 16'h1234, 0, 0, 0);
            run(k, 7'h7F, 8'h3C, 16'hFE01, 0, 0, 0);
            run(k, 7'h2A, 8'h00, 16'h80FF, 0, 1, 0);
        end
        for (int k = 0; k < 8; k++)
            for (int s = 0; s < exp_len(k); s++)
                for (int f = 2; f <= 4; f++)
                    run(k, 7'h55, 8'h9E, 16'hC0DE, s, f, 0);
        for (int k = 0; k < 8; k++)
            run(k, 7'h11, 8'h42, 16'hBEEF, exp_len(k) - 1, 5, 0);
        run(7, 7'h33, 8'h77, 16'h0000, 2, 5, 0);
        for (int k = 8; k < 16; k++)
            run(k, 7'h12, 8'h34, 16'h5678, 0, 0, 0);
        run(6, 7'h4D, 8'h5E, 16'hA55A, 0, 0, 1);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule